// File: doc/BRIEF.md
# Reorder Buffer for In-Order Commit

This block is a circular buffer that keeps instructions in program order while their results arrive out of order. When an instruction is dispatched it takes the slot at the tail. The slot index goes back to the dispatcher as the rename tag of that instruction. Execution units later broadcast a result together with its tag. The buffer stores the value in the matching slot and marks the slot complete. The oldest slot retires only once its result is present. Retiring a register-writing instruction updates the architectural register file. Retiring a store presents the value at the commit outputs.

A rename table records, for each architectural register, the tag of the youngest in-flight instruction that will write it. Dispatch logic looks up source registers through a set of lookup ports. Each port returns the architectural value, the forwarded value of a completed but uncommitted slot, or the tag still awaited. A mispredicted branch or an instruction flagged with an exception is noticed when it reaches the head. At that point every younger slot is discarded, all pending renames are cleared, and for an exception a precise-exception output is raised.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: disp_ready is 1, disp_tag is 0, commit_valid, flush and exc_raise are 0, and every lookup reports ready with value 0.
- R2: An accepted dispatch (disp_valid and disp_ready in the same cycle) takes the slot shown on disp_tag, and the next slot is the previous tag plus one, modulo the buffer depth.
- R3: Once the buffer holds depth uncommitted entries, disp_ready is 0, and a dispatch attempted in that state is ignored: disp_tag keeps its value.
- R4: A result on the result bus whose tag names an allocated slot is stored in that slot. From the following cycle, a lookup of that slot's destination register reports ready with the stored value, even before the slot commits.
- R5: A lookup of a register whose newest in-flight producer has not completed reports not ready, together with that producer's tag.
- R6: commit_valid is 1 exactly when the oldest slot has its result. A completed younger slot never commits ahead of an incomplete older one, and commits take place in program order, one per cycle, on the clock edge that ends the cycle in which commit_valid is 1.
- R7: Committing a register-writing kind (disp_kind 2'b00) writes its value to the architectural register. The register's pending mark is cleared only if it still names the committing slot, so a younger producer of the same register stays visible.
- R8: A store kind (disp_kind 2'b01) commits with commit_kind 2'b01 and leaves the architectural register named in its destination field unchanged.
- R9: A slot completed with res_mispred set raises flush in the cycle it is at the head. After that edge the buffer is empty, the next dispatch tag is the slot after the branch, and all lookups report ready with architectural values.
- R10: A slot completed with res_excpt set raises exc_raise and flush together at the head. Its value is not written to any register, and younger slots are discarded.
- R11: A result whose tag names a free slot is ignored: a later dispatch into that slot still reports its destination as not ready.
- R12: While flush is 1, disp_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_kind | input | 2 | 00 register write, 01 store, 10 branch |
| disp_dest | input | REG_W | Destination register of the dispatched instruction |
| disp_ready | output | 1 | A slot is free and no flush is in progress |
| disp_tag | output | IDX_W | Slot (rename tag) the next dispatch takes |
| src_reg | input | NSRC*REG_W | Source registers looked up, one field per port |
| src_ready | output | NSRC | Operand value available, per port |
| src_tag | output | NSRC*IDX_W | Awaited producer tag when not ready, per port |
| src_value | output | NSRC*DATA_W | Operand value when ready, per port |
| res_valid | input | 1 | Result bus broadcast valid |
| res_tag | input | IDX_W | Slot that produced the result |
| res_value | input | DATA_W | Result value |
| res_mispred | input | 1 | Completing branch was mispredicted |
| res_excpt | input | 1 | Completing instruction raised an exception |
| commit_valid | output | 1 | Head slot retires at the coming edge |
| commit_kind | output | 2 | Kind of the head slot |
| commit_dest | output | REG_W | Destination of the head slot |
| commit_value | output | DATA_W | Value of the head slot |
| flush | output | 1 | Head retirement discards all younger slots |
| exc_raise | output | 1 | Head retirement is a precise exception |

## Verification
The hardest state to reach is a completely full buffer whose oldest slot is a mispredicted branch. In that state the wrap bits of the two pointers differ while their indices match, so both the ignored dispatch and the recovery of the tail pointer are exercised at once. The stimulus reaches it by dispatching a branch followed by depth minus one register writes with no results. It then tries one more dispatch, and only after that completes the branch as mispredicted. Out-of-order completion, a repeated destination whose older producer commits first, and a stale result sent to a free slot are each driven by directed sequences. Every outcome is observed through the lookup ports.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        K_REG    = 2'b00,
        K_STORE  = 2'b01,
        K_BRANCH = 2'b10
    } rob_kind_e;

    typedef struct packed {
        logic done;
        logic mispred;
        logic excpt;
    } rob_flags_t;

    function automatic logic kind_writes_reg(input logic [1:0] k);
        return k == K_REG;
    endfunction

    function automatic logic flags_abort(input rob_flags_t f);
        return f.mispred | f.excpt;
    endfunction

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic             full
);
    logic [IDX_W:0] head_q, tail_q, head_d, tail_d;

    always_comb begin
        head_d = pop ? head_q + 1'b1 : head_q;
        if (flush)
            tail_d = head_d;
        else if (push)
            tail_d = tail_q + 1'b1;
        else
            tail_d = tail_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_d;
            tail_q <= tail_d;
        end
    end

    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];
    assign full     = (head_q[IDX_W] != tail_q[IDX_W]) &&
                      (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]);
endmodule

// File: rtl/rob_store.sv
module rob_store
    import rob_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int REG_W  = 4,
    parameter int DATA_W = 32,
    parameter int NSRC   = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             alloc,
    input  logic [IDX_W-1:0]                 alloc_idx,
    input  logic [1:0]                       alloc_kind,
    input  logic [REG_W-1:0]                 alloc_dest,
    input  logic                             res_valid,
    input  logic [IDX_W-1:0]                 res_tag,
    input  logic [DATA_W-1:0]                res_value,
    input  logic                             res_mispred,
    input  logic                             res_excpt,
    input  logic                             retire,
    input  logic                             flush,
    input  logic [IDX_W-1:0]                 head_idx,
    output logic                             hd_valid,
    output logic [1:0]                       hd_kind,
    output logic [REG_W-1:0]                 hd_dest,
    output logic [DATA_W-1:0]                hd_value,
    output rob_flags_t                       hd_flags,
    input  logic [NSRC-1:0][IDX_W-1:0]       rd_tag,
    output logic [NSRC-1:0]                  rd_done,
    output logic [NSRC-1:0][DATA_W-1:0]      rd_value
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]  valid;
    rob_flags_t        flags [DEPTH];
    logic [1:0]        kind  [DEPTH];
    logic [REG_W-1:0]  dest  [DEPTH];
    logic [DATA_W-1:0] value [DEPTH];

    logic capture;
    assign capture = res_valid && valid[res_tag];

    // occupancy and completion flags
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
            for (int i = 0; i < DEPTH; i++)
                flags[i] <= '0;
        end else begin
            if (capture) begin
                flags[res_tag].done    <= 1'b1;
                flags[res_tag].mispred <= res_mispred;
                flags[res_tag].excpt   <= res_excpt;
            end
            if (alloc)
                flags[alloc_idx] <= '0;
            if (flush) begin
                valid <= '0;
            end else begin
                if (retire)
                    valid[head_idx] <= 1'b0;
                if (alloc)
                    valid[alloc_idx] <= 1'b1;
            end
        end
    end

    // payload, qualified by the flags above
    always_ff @(posedge clk) begin
        if (capture)
            value[res_tag] <= res_value;
        if (alloc) begin
            kind[alloc_idx] <= alloc_kind;
            dest[alloc_idx] <= alloc_dest;
        end
    end

    assign hd_valid = valid[head_idx];
    assign hd_kind  = kind[head_idx];
    assign hd_dest  = dest[head_idx];
    assign hd_value = value[head_idx];
    assign hd_flags = flags[head_idx];

    for (genvar g = 0; g < NSRC; g++) begin : g_rd
        assign rd_done[g]  = valid[rd_tag[g]] && flags[rd_tag[g]].done;
        assign rd_value[g] = value[rd_tag[g]];
    end
endmodule

// File: rtl/rob_rename.sv
module rob_rename #(
    parameter int IDX_W  = 3,
    parameter int REG_W  = 4,
    parameter int DATA_W = 32,
    parameter int NSRC   = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         set_en,
    input  logic [REG_W-1:0]             set_reg,
    input  logic [IDX_W-1:0]             set_tag,
    input  logic                         clr_en,
    input  logic [REG_W-1:0]             clr_reg,
    input  logic [IDX_W-1:0]             clr_tag,
    input  logic                         wr_en,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         flush,
    input  logic [NSRC-1:0][REG_W-1:0]   lk_reg,
    output logic [NSRC-1:0]              lk_pend,
    output logic [NSRC-1:0][IDX_W-1:0]   lk_tag,
    output logic [NSRC-1:0][DATA_W-1:0]  lk_arch
);
    localparam int NREG = 1 << REG_W;

    logic [NREG-1:0]   pend;
    logic [IDX_W-1:0]  tagq [NREG];
    logic [DATA_W-1:0] rf   [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (flush) begin
            pend <= '0;
        end else begin
            if (clr_en && pend[clr_reg] && (tagq[clr_reg] == clr_tag))
                pend[clr_reg] <= 1'b0;
            if (set_en)
                pend[set_reg] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en)
            tagq[set_reg] <= set_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++)
                rf[i] <= '0;
        end else if (wr_en) begin
            rf[clr_reg] <= wr_data;
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_lk
        assign lk_pend[g] = pend[lk_reg[g]];
        assign lk_tag[g]  = tagq[lk_reg[g]];
        assign lk_arch[g] = rf[lk_reg[g]];
    end
endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int REG_W  = 4,
    parameter int DATA_W = 32,
    parameter int NSRC   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     disp_valid,
    input  logic [1:0]               disp_kind,
    input  logic [REG_W-1:0]         disp_dest,
    output logic                     disp_ready,
    output logic [IDX_W-1:0]         disp_tag,
    input  logic [NSRC*REG_W-1:0]    src_reg,
    output logic [NSRC-1:0]          src_ready,
    output logic [NSRC*IDX_W-1:0]    src_tag,
    output logic [NSRC*DATA_W-1:0]   src_value,
    input  logic                     res_valid,
    input  logic [IDX_W-1:0]         res_tag,
    input  logic [DATA_W-1:0]        res_value,
    input  logic                     res_mispred,
    input  logic                     res_excpt,
    output logic                     commit_valid,
    output logic [1:0]               commit_kind,
    output logic [REG_W-1:0]         commit_dest,
    output logic [DATA_W-1:0]        commit_value,
    output logic                     flush,
    output logic                     exc_raise
);
    logic [IDX_W-1:0] head_idx, tail_idx;
    logic             full, accept;

    logic             hd_valid;
    logic [1:0]       hd_kind;
    logic [REG_W-1:0] hd_dest;
    logic [DATA_W-1:0] hd_value;
    rob_flags_t       hd_flags;

    logic [NSRC-1:0][REG_W-1:0]  lk_reg;
    logic [NSRC-1:0]             lk_pend;
    logic [NSRC-1:0][IDX_W-1:0]  lk_tag;
    logic [NSRC-1:0][DATA_W-1:0] lk_arch;
    logic [NSRC-1:0]             rd_done;
    logic [NSRC-1:0][DATA_W-1:0] rd_value;

    logic hd_writes;

    assign commit_valid = hd_valid && hd_flags.done;
    assign flush        = commit_valid && flags_abort(hd_flags);
    assign exc_raise    = commit_valid && hd_flags.excpt;
    assign disp_ready   = !full && !flush;
    assign accept       = disp_valid && disp_ready;
    assign disp_tag     = tail_idx;
    assign hd_writes    = kind_writes_reg(hd_kind);

    assign commit_kind  = hd_kind;
    assign commit_dest  = hd_dest;
    assign commit_value = hd_value;

    rob_ptrs #(.IDX_W(IDX_W)) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .push     (accept),
        .pop      (commit_valid),
        .flush    (flush),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .full     (full)
    );

    rob_store #(
        .IDX_W(IDX_W), .REG_W(REG_W), .DATA_W(DATA_W), .NSRC(NSRC)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .alloc       (accept),
        .alloc_idx   (tail_idx),
        .alloc_kind  (disp_kind),
        .alloc_dest  (disp_dest),
        .res_valid   (res_valid),
        .res_tag     (res_tag),
        .res_value   (res_value),
        .res_mispred (res_mispred),
        .res_excpt   (res_excpt),
        .retire      (commit_valid),
        .flush       (flush),
        .head_idx    (head_idx),
        .hd_valid    (hd_valid),
        .hd_kind     (hd_kind),
        .hd_dest     (hd_dest),
        .hd_value    (hd_value),
        .hd_flags    (hd_flags),
        .rd_tag      (lk_tag),
        .rd_done     (rd_done),
        .rd_value    (rd_value)
    );

    rob_rename #(
        .IDX_W(IDX_W), .REG_W(REG_W), .DATA_W(DATA_W), .NSRC(NSRC)
    ) u_rename (
        .clk     (clk),
        .rst     (rst),
        .set_en  (accept && kind_writes_reg(disp_kind)),
        .set_reg (disp_dest),
        .set_tag (tail_idx),
        .clr_en  (commit_valid && hd_writes),
        .clr_reg (hd_dest),
        .clr_tag (head_idx),
        .wr_en   (commit_valid && hd_writes && !hd_flags.excpt),
        .wr_data (hd_value),
        .flush   (flush),
        .lk_reg  (lk_reg),
        .lk_pend (lk_pend),
        .lk_tag  (lk_tag),
        .lk_arch (lk_arch)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign lk_reg[g] = src_reg[g*REG_W +: REG_W];
        assign src_ready[g] = lk_pend[g] ? rd_done[g] : 1'b1;
        assign src_tag[g*IDX_W +: IDX_W] = lk_pend[g] ? lk_tag[g] : '0;
        assign src_value[g*DATA_W +: DATA_W] =
            !lk_pend[g] ? lk_arch[g] : (rd_done[g] ? rd_value[g] : '0);
    end
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic [IDX_W-1:0] disp_tag,
    input logic             commit_valid,
    input logic             flush,
    input logic             exc_raise
);
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W:0] occ;
    logic           acc;
    assign acc = disp_valid && disp_ready;

    always_ff @(posedge clk) begin
        if (rst)
            occ <= '0;
        else if (flush)
            occ <= '0;
        else if (acc && !commit_valid)
            occ <= occ + 1'b1;
        else if (!acc && commit_valid)
            occ <= occ - 1'b1;
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        occ <= (IDX_W+1)'(DEPTH));

    p_full_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        (occ == (IDX_W+1)'(DEPTH)) |-> !disp_ready);

    p_tag_sequence_r2: assert property (@(posedge clk) disable iff (rst)
        acc |=> disp_tag == IDX_W'($past(disp_tag) + 1'b1));

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (disp_ready && !commit_valid));

    p_exc_flushes_r10: assert property (@(posedge clk) disable iff (rst)
        exc_raise |-> (flush && commit_valid));

    p_flush_stalls_r12: assert property (@(posedge clk) disable iff (rst)
        flush |-> !disp_ready);
endmodule

bind rob_core rob_core_chk #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .disp_valid   (disp_valid),
    .disp_ready   (disp_ready),
    .disp_tag     (disp_tag),
    .commit_valid (commit_valid),
    .flush        (flush),
    .exc_raise    (exc_raise)
);

// File: tb/tb_rob_core.sv
`timescale 1ns/1ps
module tb_rob_core;
    localparam int IDX_W  = 3;
    localparam int REG_W  = 4;
    localparam int DATA_W = 32;
    localparam int NSRC   = 2;
    localparam int DEPTH  = 1 << IDX_W;
    localparam logic [1:0] KREG = 2'b00, KST = 2'b01, KBR = 2'b10;

    localparam logic [35:0] VEC [8] = '{
        {4'd1,  32'h1111_0001}, {4'd2,  32'h2222_0002},
        {4'd3,  32'h3333_0003}, {4'd4,  32'h4444_0004},
        {4'd9,  32'h9999_0009}, {4'd10, 32'hAAAA_000A},
        {4'd11, 32'hBBBB_000B}, {4'd8,  32'h8888_0008}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic disp_valid = 1'b0;
    logic [1:0] disp_kind = '0;
    logic [REG_W-1:0] disp_dest = '0;
    logic disp_ready;
    logic [IDX_W-1:0] disp_tag;
    logic [NSRC*REG_W-1:0] src_reg = '0;
    logic [NSRC-1:0] src_ready;
    logic [NSRC*IDX_W-1:0] src_tag;
    logic [NSRC*DATA_W-1:0] src_value;
    logic res_valid = 1'b0;
    logic [IDX_W-1:0] res_tag = '0;
    logic [DATA_W-1:0] res_value = '0;
    logic res_mispred = 1'b0;
    logic res_excpt = 1'b0;
    logic commit_valid;
    logic [1:0] commit_kind;
    logic [REG_W-1:0] commit_dest;
    logic [DATA_W-1:0] commit_value;
    logic flush, exc_raise;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [DATA_W-1:0] arch [16];
    int nt = 0;

    always #2.5 clk = ~clk;

    rob_core #(.IDX_W(IDX_W), .REG_W(REG_W), .DATA_W(DATA_W), .NSRC(NSRC)) dut (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_kind(disp_kind), .disp_dest(disp_dest),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .src_reg(src_reg), .src_ready(src_ready), .src_tag(src_tag), .src_value(src_value),
        .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
        .res_mispred(res_mispred), .res_excpt(res_excpt),
        .commit_valid(commit_valid), .commit_kind(commit_kind),
        .commit_dest(commit_dest), .commit_value(commit_value),
        .flush(flush), .exc_raise(exc_raise)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic dispatch(input logic [1:0] k, input logic [REG_W-1:0] d);
        disp_valid = 1'b1; disp_kind = k; disp_dest = d;
        step();
        disp_valid = 1'b0;
        #1;
    endtask

    task automatic result(input int t, input logic [DATA_W-1:0] v,
                          input logic mis, input logic exc);
        res_valid = 1'b1; res_tag = IDX_W'(t); res_value = v;
        res_mispred = mis; res_excpt = exc;
        step();
        res_valid = 1'b0; res_mispred = 1'b0; res_excpt = 1'b0;
        #1;
    endtask

    task automatic look(input int p, input logic [REG_W-1:0] r, output logic rdy,
                        output logic [IDX_W-1:0] tg, output logic [DATA_W-1:0] val);
        src_reg[p*REG_W +: REG_W] = r;
        #1;
        rdy = src_ready[p];
        tg  = src_tag[p*IDX_W +: IDX_W];
        val = src_value[p*DATA_W +: DATA_W];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic rdy;
        logic [IDX_W-1:0] tg;
        logic [DATA_W-1:0] val;
        int t0, t1, bt;

        for (int i = 0; i < 16; i++) arch[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;

        // R1: reset state
        chk("R1 disp_ready", disp_ready, 1);
        chk("R1 disp_tag", disp_tag, 0);
        chk("R1 commit_valid", commit_valid, 0);
        chk("R1 flush", flush, 0);
        chk("R1 exc_raise", exc_raise, 0);
        look(0, 4'd4, rdy, tg, val);
        chk("R1 lookup ready", rdy, 1);
        chk("R1 lookup value", val, 0);

        // vector table: dispatch, complete, commit, read back
        for (int i = 0; i < 8; i++) begin
            logic [REG_W-1:0] d;
            logic [DATA_W-1:0] v;
            d = VEC[i][35:32];
            v = VEC[i][31:0];
            #0;
            chk("R2 tag before dispatch", disp_tag, nt);
            dispatch(KREG, d);
            result(nt, v, 1'b0, 1'b0);
            chk("R6 commit_valid", commit_valid, 1);
            chk("R6 commit_value", commit_value, v);
            step();
            arch[d] = v;
            nt = (nt + 1) % DEPTH;
            look(0, d, rdy, tg, val);
            chk("R7 arch value after commit", {rdy, val}, {1'b1, v});
        end

        // R4 R5 R6: out-of-order completion
        t0 = nt; dispatch(KREG, 4'd5);
        t1 = (nt + 1) % DEPTH; dispatch(KREG, 4'd6);
        nt = (nt + 2) % DEPTH;
        result(t1, 32'h0000_0066, 1'b0, 1'b0);
        chk("R6 younger done, no commit", commit_valid, 0);
        look(0, 4'd6, rdy, tg, val);
        chk("R4 forwarded value", {rdy, val}, {1'b1, 32'h0000_0066});
        look(1, 4'd5, rdy, tg, val);
        chk("R5 pending ready", rdy, 0);
        chk("R5 pending tag", tg, t0);
        result(t0, 32'h0000_0055, 1'b0, 1'b0);
        chk("R6 head commits first", {commit_valid, commit_dest}, {1'b1, 4'd5});
        step();
        chk("R6 second commit", {commit_valid, commit_dest, commit_value},
            {1'b1, 4'd6, 32'h0000_0066});
        step();
        arch[5] = 32'h55; arch[6] = 32'h66;
        chk("R6 idle after both", commit_valid, 0);

        // R7: repeated destination
        t0 = nt; dispatch(KREG, 4'd7);
        t1 = (nt + 1) % DEPTH; dispatch(KREG, 4'd7);
        nt = (nt + 2) % DEPTH;
        result(t0, 32'h0000_077A, 1'b0, 1'b0);
        step();
        look(0, 4'd7, rdy, tg, val);
        chk("R7 younger producer still pending", {rdy, tg}, {1'b0, IDX_W'(t1)});
        result(t1, 32'h0000_077B, 1'b0, 1'b0);
        step();
        arch[7] = 32'h77B;
        look(0, 4'd7, rdy, tg, val);
        chk("R7 final value", {rdy, val}, {1'b1, 32'h0000_077B});

        // R8: store does not write the register file
        t0 = nt; dispatch(KST, 4'd9);
        nt = (nt + 1) % DEPTH;
        result(t0, 32'hDEAD_0000, 1'b0, 1'b0);
        chk("R8 store commit kind", {commit_valid, commit_kind}, {1'b1, KST});
        step();
        look(0, 4'd9, rdy, tg, val);
        chk("R8 register untouched", {rdy, val}, {1'b1, arch[9]});

        // R3 R9 R12: full buffer with mispredicted branch at head
        bt = nt;
        dispatch(KBR, 4'd0);
        for (int k = 1; k < DEPTH; k++) dispatch(KREG, REG_W'(k));
        chk("R3 full blocks dispatch", disp_ready, 0);
        dispatch(KREG, 4'd3);
        chk("R3 ignored dispatch keeps tag", disp_tag, bt);
        look(0, 4'd2, rdy, tg, val);
        chk("R5 pending while full", rdy, 0);
        result(bt, '0, 1'b1, 1'b0);
        chk("R9 flush raised", {flush, exc_raise}, {1'b1, 1'b0});
        chk("R12 no dispatch during flush", disp_ready, 0);
        step();
        chk("R9 empty after flush", {commit_valid, disp_ready}, {1'b0, 1'b1});
        chk("R9 next tag after branch", disp_tag, (bt + 1) % DEPTH);
        look(0, 4'd3, rdy, tg, val);
        chk("R9 lookup architectural", {rdy, val}, {1'b1, arch[3]});
        nt = (bt + 1) % DEPTH;

        // R10: precise exception
        t0 = nt; dispatch(KREG, 4'd10);
        dispatch(KREG, 4'd11);
        result(t0, 32'h0000_0BAD, 1'b0, 1'b1);
        chk("R10 exc and flush", {exc_raise, flush}, 2'b11);
        step();
        look(0, 4'd10, rdy, tg, val);
        chk("R10 no write", {rdy, val}, {1'b1, arch[10]});
        look(1, 4'd11, rdy, tg, val);
        chk("R10 younger discarded", {rdy, val}, {1'b1, arch[11]});
        chk("R10 next tag", disp_tag, (t0 + 1) % DEPTH);
        nt = (t0 + 1) % DEPTH;

        // R11: stale result to a free slot
        t0 = nt;
        result(t0, 32'h0000_1234, 1'b0, 1'b0);
        chk("R11 no commit from free slot", commit_valid, 0);
        chk("R11 tag", disp_tag, t0);
        dispatch(KREG, 4'd12);
        nt = (nt + 1) % DEPTH;
        look(0, 4'd12, rdy, tg, val);
        chk("R11 new slot not ready", {rdy, tg}, {1'b0, IDX_W'(t0)});
        result(t0, 32'h0000_C0C0, 1'b0, 1'b0);
        step();
        look(0, 4'd12, rdy, tg, val);
        chk("R11 later completion", {rdy, val}, {1'b1, 32'h0000_C0C0});

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule